// File: doc/BRIEF.md
# Dual-Timer Mode Control Register

This block keeps the operating-mode state for two 8-bit timer channels, called A and B. The two channels can also be joined into a single 16-bit timer. Each channel has a 4-bit mode field and a run bit. One more register holds the 16-bit join bit. Software reaches all of this through a simple single-cycle write port and a combinational read port. The counters, PWM generators and capture units sit outside this block. They use the registered mode, run and join values, together with a one-hot class vector for each channel that tells them which family of functions the channel's code selects.

The block also applies the rules that tie the two channels together. A running channel keeps its mode field: a write may change its run bit but not its mode. When a stopped channel is started in variable-cycle PWM mode (code 0100), the partner channel's mode field is loaded with 0100 and the join bit is cleared. Both changes happen on the same clock edge as the start. Either channel can trigger this.

Register map with default parameters:

| Address | Contents |
|---------|----------|
| 0 | Channel A: mode in bits [3:0], run bit in bit 4 |
| 1 | Channel B: mode in bits [3:0], run bit in bit 4 |
| 2 | Join bit in bit 0 |

Mode codes:

| Code | Function |
|------|----------|
| 0000 | One-shot interval |
| 0001 | Continuous interval |
| 0010 | Free-run interval |
| 0011 | Fixed-cycle PWM |
| 0100 | Variable-cycle PWM |
| 0101 to 1001 | Pulse-width measurement |
| 1010 to 1111 | Input capture |

Top module: `dual_timer_mode_reg`

## Requirements
- R1: After reset both mode fields are 0000, both run bits are 0 and the join bit is 0.
- R2: A write to address 0 (channel A) or address 1 (channel B) while that channel's run bit is 0 stores data bits [3:0] as the mode and data bit 4 as the run bit. Both are visible from the next clock edge.
- R3: A write to a channel whose run bit is already 1 updates only its run bit. The mode field keeps its old value.
- R4: A write that sets the run bit of a stopped channel with mode data 0100 also loads 0100 into the other channel's mode field on the same edge. This happens even if the other channel is running.
- R5: A start as in R4 clears the join bit on the same edge.
- R6: The R4 and R5 rules apply to a start on channel A and to a start on channel B.
- R7: Starting a channel in any mode other than 0100, or rewriting a channel that is already running, leaves the partner's mode field and the join bit unchanged.
- R8: Each channel's class output is one-hot. Bit 0 means interval (codes 0-2), bit 1 means PWM (codes 3-4), bit 2 means pulse-width measurement (codes 5-9) and bit 3 means capture (codes 10-15).
- R9: A write to address 2 loads data bit 0 into the join bit at any time, and changes no channel field.
- R10: A read of address 0 or 1 returns {zeros, run, mode} with the current values, forced values included. A read of address 2 returns the join bit in bit 0. A read of address 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | DATA_W | Read data, combinational |
| modeA | output | 4 | Channel A mode field |
| modeB | output | 4 | Channel B mode field |
| runA | output | 1 | Channel A run bit |
| runB | output | 1 | Channel B run bit |
| join16 | output | 1 | 16-bit join bit |
| classA | output | 4 | Channel A one-hot mode class |
| classB | output | 4 | Channel B one-hot mode class |

## Verification
The bench builds the block with its default parameters: a 2-bit address, 8-bit data and the register addresses 0, 1 and 2. This puts all sixteen mode codes within reach of both channels, along with the unmapped fourth address and the data bits above the run bit, which must read back as zero. About a quarter of the random writes carry mode 0100, so the forced-partner and join-clear paths are hit many times from both channels, while stopped, while running and while the partner is running.

// File: rtl/dual_timer_mode_pkg.sv
package dual_timer_mode_pkg;

  localparam int MODE_W = 4;
  localparam int CLS_W  = 4;

  localparam logic [MODE_W-1:0] MODE_PWM_VAR = 4'b0100;

  // class vector bit positions
  localparam int CLS_INTERVAL = 0;
  localparam int CLS_PWM      = 1;
  localparam int CLS_PWC      = 2;
  localparam int CLS_CAPTURE  = 3;

  // strobes passed from control to the register datapath
  typedef struct packed {
    logic [1:0]        modeWe;   // accept new mode for channel i
    logic [1:0]        runWe;    // load run bit for channel i
    logic [MODE_W-1:0] modeVal;
    logic              runVal;
    logic [1:0]        forceVar; // load variable-cycle PWM into channel i
    logic              joinWe;
    logic              joinVal;
    logic              joinClr;
  } mode_strobe_t;

endpackage

// File: rtl/dual_timer_mode_ctrl.sv
module dual_timer_mode_ctrl
  import dual_timer_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CH_A_ADDR = 0,
  parameter logic [ADDR_W-1:0] CH_B_ADDR = 1,
  parameter logic [ADDR_W-1:0] JOIN_ADDR = 2,
  parameter int JOIN_POS = 0
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        runQ,
  output mode_strobe_t      stb
);

  localparam int RUN_POS = MODE_W;

  logic [MODE_W-1:0] wrMode;
  logic              wrRun;
  logic [1:0]        chSel;
  logic [1:0]        startVar;

  assign wrMode = wrData[MODE_W-1:0];
  assign wrRun  = wrData[RUN_POS];

  for (genvar i = 0; i < 2; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = (i == 0) ? CH_A_ADDR : CH_B_ADDR;
    assign chSel[i] = wrEn && (wrAddr == MY_ADDR);
    // only a stopped channel can start, and only then does its mode data land
    assign startVar[i] = chSel[i] && wrRun && !runQ[i] && (wrMode == MODE_PWM_VAR);
  end

  always_comb begin
    stb          = '0;
    stb.modeVal  = wrMode;
    stb.runVal   = wrRun;
    stb.joinVal  = wrData[JOIN_POS];
    stb.joinWe   = wrEn && (wrAddr == JOIN_ADDR);
    for (int i = 0; i < 2; i++) begin
      stb.runWe[i]  = chSel[i];
      stb.modeWe[i] = chSel[i] && !runQ[i];
    end
    stb.forceVar[0] = startVar[1];
    stb.forceVar[1] = startVar[0];
    stb.joinClr     = |startVar;
  end

endmodule

// File: rtl/dual_timer_mode_dp.sv
module dual_timer_mode_dp
  import dual_timer_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CH_A_ADDR = 0,
  parameter logic [ADDR_W-1:0] CH_B_ADDR = 1,
  parameter logic [ADDR_W-1:0] JOIN_ADDR = 2,
  parameter int JOIN_POS = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  mode_strobe_t      stb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [MODE_W-1:0] modeQ [2],
  output logic [1:0]        runQ,
  output logic              joinQ,
  output logic [CLS_W-1:0]  classVec [2]
);

  localparam int RUN_POS = MODE_W;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        modeQ[i] <= '0;
        runQ[i]  <= 1'b0;
      end else begin
        if (stb.forceVar[i])    modeQ[i] <= MODE_PWM_VAR;
        else if (stb.modeWe[i]) modeQ[i] <= stb.modeVal;
        if (stb.runWe[i])       runQ[i]  <= stb.runVal;
      end
    end

    always_comb begin
      classVec[i] = '0;
      if (modeQ[i] <= 4'd2)      classVec[i][CLS_INTERVAL] = 1'b1;
      else if (modeQ[i] <= 4'd4) classVec[i][CLS_PWM]      = 1'b1;
      else if (modeQ[i] <= 4'd9) classVec[i][CLS_PWC]      = 1'b1;
      else                       classVec[i][CLS_CAPTURE]  = 1'b1;
    end

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (runQ[i] && !stb.forceVar[i]) |=> (modeQ[i] == $past(modeQ[i])));

    // R8
    class_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot(classVec[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            joinQ <= 1'b0;
    else if (stb.joinClr) joinQ <= 1'b0;
    else if (stb.joinWe)  joinQ <= stb.joinVal;
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == CH_A_ADDR) begin
      rdData[MODE_W-1:0] = modeQ[0];
      rdData[RUN_POS]    = runQ[0];
    end else if (rdAddr == CH_B_ADDR) begin
      rdData[MODE_W-1:0] = modeQ[1];
      rdData[RUN_POS]    = runQ[1];
    end else if (rdAddr == JOIN_ADDR) begin
      rdData[JOIN_POS]   = joinQ;
    end
  end

endmodule

// File: rtl/dual_timer_mode_reg.sv
module dual_timer_mode_reg
  import dual_timer_mode_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CH_A_ADDR = 0,
  parameter logic [ADDR_W-1:0] CH_B_ADDR = 1,
  parameter logic [ADDR_W-1:0] JOIN_ADDR = 2,
  parameter int JOIN_POS = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [3:0]        modeA,
  output logic [3:0]        modeB,
  output logic              runA,
  output logic              runB,
  output logic              join16,
  output logic [3:0]        classA,
  output logic [3:0]        classB
);

  mode_strobe_t      stb;
  logic [MODE_W-1:0] modeQ [2];
  logic [1:0]        runQ;
  logic [CLS_W-1:0]  classVec [2];
  logic              unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:MODE_W+1];

  dual_timer_mode_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_A_ADDR(CH_A_ADDR),
    .CH_B_ADDR(CH_B_ADDR), .JOIN_ADDR(JOIN_ADDR), .JOIN_POS(JOIN_POS)
  ) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .runQ(runQ), .stb(stb)
  );

  dual_timer_mode_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_A_ADDR(CH_A_ADDR),
    .CH_B_ADDR(CH_B_ADDR), .JOIN_ADDR(JOIN_ADDR), .JOIN_POS(JOIN_POS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .rdData(rdData),
    .modeQ(modeQ), .runQ(runQ), .joinQ(join16), .classVec(classVec)
  );

  assign modeA  = modeQ[0];
  assign modeB  = modeQ[1];
  assign runA   = runQ[0];
  assign runB   = runQ[1];
  assign classA = classVec[0];
  assign classB = classVec[1];

  // R2
  mode_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == CH_A_ADDR && !runA) |=> (modeA == $past(wrData[3:0])));

  // R4
  partner_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(runA) && modeA == MODE_PWM_VAR) |-> (modeB == MODE_PWM_VAR));

  // R5
  join_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(runB) && modeB == MODE_PWM_VAR) |-> !join16);

  // R9
  join_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == JOIN_ADDR) |=> (join16 == $past(wrData[JOIN_POS])));

endmodule

// File: tb/sim_dual_timer_mode_reg.sv
`timescale 1ns/1ps
module sim_dual_timer_mode_reg;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [3:0] modeA, modeB, classA, classB;
  logic       runA, runB, join16;

  always #2.5 clk = ~clk;

  dual_timer_mode_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .modeA(modeA), .modeB(modeB),
    .runA(runA), .runB(runB), .join16(join16), .classA(classA), .classB(classB)
  );

  int checks = 0;
  int fails  = 0;
  logic [3:0] mRef [2];
  logic       rRef [2];
  logic       jRef;

  function automatic logic [3:0] expClass(logic [3:0] m);
    if (m <= 4'd2) return 4'b0001;
    if (m <= 4'd4) return 4'b0010;
    if (m <= 4'd9) return 4'b0100;
    return 4'b1000;
  endfunction

  function automatic logic [7:0] expRead(logic [1:0] a);
    if (a == 2'd0) return {3'b0, rRef[0], mRef[0]};
    if (a == 2'd1) return {3'b0, rRef[1], mRef[1]};
    if (a == 2'd2) return {7'b0, jRef};
    return 8'h00;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic refUpdate(logic [1:0] a, logic [7:0] d);
    if (a <= 2'd1) begin
      int ch = int'(a);
      bit varStart = d[4] && !rRef[ch] && d[3:0] == 4'b0100;
      if (!rRef[ch]) mRef[ch] = d[3:0];
      rRef[ch] = d[4];
      if (varStart) begin
        mRef[1-ch] = 4'b0100;
        jRef = 1'b0;
      end
    end else if (a == 2'd2) begin
      jRef = d[0];
    end
  endtask

  task automatic doWrite(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    refUpdate(a, d);
  endtask

  task automatic compareAll(string req);
    chk(modeA == mRef[0], req, modeA, mRef[0]);
    chk(modeB == mRef[1], req, modeB, mRef[1]);
    chk(runA == rRef[0], req, runA, rRef[0]);
    chk(runB == rRef[1], req, runB, rRef[1]);
    chk(join16 == jRef, req, join16, jRef);
    chk(classA == expClass(mRef[0]), "R8", classA, expClass(mRef[0]));
    chk(classB == expClass(mRef[1]), "R8", classB, expClass(mRef[1]));
    for (int a = 0; a < 4; a++) begin
      rdAddr = 2'(a);
      #0.1;
      chk(rdData == expRead(2'(a)), "R10", rdData, expRead(2'(a)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin mRef[i] = '0; rRef[i] = 1'b0; end
    jRef = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1");

    doWrite(2'd0, 8'h05); compareAll("R2");   // store pwc mode, stopped
    doWrite(2'd0, 8'h15); compareAll("R2");   // start A in mode 5
    doWrite(2'd0, 8'h17); compareAll("R3");   // mode write ignored while running
    doWrite(2'd2, 8'h01); compareAll("R9");   // set join
    doWrite(2'd1, 8'h1A); compareAll("R7");   // start B in capture: join stays
    doWrite(2'd1, 8'h00); compareAll("R3");   // stop B, mode kept
    doWrite(2'd1, 8'h14); compareAll("R4");   // B var start forces running A
    chk(modeA == 4'b0100, "R6", modeA, 4'b0100);
    chk(join16 == 1'b0, "R5", join16, 1'b0);
    doWrite(2'd0, 8'h00); doWrite(2'd1, 8'h00);
    doWrite(2'd1, 8'h03); doWrite(2'd2, 8'h01);
    doWrite(2'd0, 8'h14); compareAll("R6");   // A var start forces B
    chk(modeB == 4'b0100, "R6", modeB, 4'b0100);
    chk(join16 == 1'b0, "R5", join16, 1'b0);
    doWrite(2'd2, 8'h01);
    doWrite(2'd0, 8'h14); compareAll("R7");   // already running: no clear
    chk(join16 == 1'b1, "R7", join16, 1'b1);
    doWrite(2'd3, 8'hFF); compareAll("R10");  // unmapped write has no effect

    void'($urandom(32'd7531));
    for (int k = 0; k < 600; k++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom_range(3, 0));
      d = 8'($urandom);
      if ($urandom_range(3, 0) == 0) d[3:0] = 4'b0100;
      doWrite(a, d);
      compareAll("R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule